// File: doc/BRIEF.md
# PWM Double-Buffered Reload Controller

This block is the timing core of one PWM channel group. A prescaled up-counter runs from a start value to a period limit and then wraps. The start value, a mid-cycle compare value, the period limit and the clock divide code are each held twice. Software writes a staged copy. The counter and the prescaler always use a separate working copy. Staged values move into the working copy only when software arms the transfer with a load-permit pulse.

A mode bit selects when an armed transfer happens. In deferred mode it waits for a reload point: the mid-cycle compare, the end of the period, or both, as chosen by two enable bits. In immediate mode it happens on the first clock after the permit is armed. The divide code can only be changed while no transfer is pending, and its read-back shows the staged code. The block also latches an external input at the end of each of two deadtime intervals. The deadtime generator marks those ends with strobes.

Top module: `pwm_reload_core`

## Requirements
- R1: On each prescaler tick the counter `cnt` advances by one. On a tick in which `cnt` is greater than or equal to the working period limit, it loads the working start value instead. Between ticks it holds its value.
- R2: With working divide code p (0 to 7), the counter advances exactly once every 2^p clocks.
- R3: Writes select a register by `wr_addr`: 0 control, 1 start value, 2 mid-cycle compare, 3 period limit. In the control word, bits [2:0] are the divide code, bit 3 enables mid-cycle reloads, bit 4 enables end-of-period reloads, and bit 5 selects immediate mode. `prsc_staged` shows the staged divide code and `prsc_live` shows the working one; the two differ until a transfer.
- R4: A control write made while `ldok` is 1 leaves the staged divide code unchanged. Its enable and mode bits are still written.
- R5: In deferred mode with end-of-period reloads enabled, an armed transfer happens on the tick in which `cnt` is at or above the working period limit.
- R6: In deferred mode with mid-cycle reloads enabled, an armed transfer happens on the tick in which `cnt` equals the working mid-cycle compare value.
- R7: With both reload enables set, a transfer can happen at both points within one counter cycle.
- R8: With both reload enables clear, no transfer happens in either mode, and `ldok` stays 1.
- R9: In immediate mode (with at least one enable set), the transfer happens on the first clock edge at which `ldok` is 1, one clock after the arming pulse.
- R10: A pulse on `ldok_arm` sets `ldok`. The clock edge that performs a transfer clears `ldok`, unless `ldok_arm` is high in that same cycle, in which case `ldok` stays 1.
- R11: A transfer restarts the prescaler, so the first counter advance comes exactly 2^p clocks after the transfer edge, where p is the new divide code.
- R12: A transfer copies the staged values held before its clock edge. A register write in that same cycle reaches only the staged copy.
- R13: `dt_stat[i]` captures `ext_in` on each clock in which `dt_done[i]` is high. Reset clears both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| ldok_arm | input | 1 | Pulse that arms a staged-to-working transfer |
| ext_in | input | 1 | External level sampled at deadtime ends |
| dt_done | input | 2 | Strobes marking the end of deadtime 0 and deadtime 1 |
| cnt | output | 16 | Counter value |
| ldok | output | 1 | Transfer armed and pending |
| reload | output | 1 | High in the cycle whose closing edge performs a transfer |
| prsc_staged | output | 3 | Staged divide code |
| prsc_live | output | 3 | Divide code in use |
| dt_stat | output | 2 | Deadtime samples |

## Verification
The collision of interest is a transfer landing in the same cycle as a write to the staged registers. The bench arms an immediate transfer and, in the cycle before its edge, writes a new period limit. It then judges from the wrap point that the old limit went live, and only a second transfer brings in the new one. The same kind of overlap is provoked between a transfer and a fresh arming pulse, which must leave the permit set. It is also provoked between an armed permit and a divide-code write, which must be dropped.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

    localparam int CNT_W    = 16;
    localparam int PRSC_W   = 3;
    localparam int DIV_W    = (1 << PRSC_W) - 1;
    localparam int NUM_DT   = 2;
    localparam int ADDR_W   = 2;

    localparam int BIT_HALF = 3;
    localparam int BIT_FULL = 4;
    localparam int BIT_MODE = 5;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_INIT = 2'd1,
        SEL_MID  = 2'd2,
        SEL_TOP  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic immediate;
        logic full_en;
        logic half_en;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0]  init;
        logic [CNT_W-1:0]  mid;
        logic [CNT_W-1:0]  top;
        logic [PRSC_W-1:0] prsc;
    } timing_t;

    function automatic logic [DIV_W-1:0] div_limit(input logic [PRSC_W-1:0] code);
        return DIV_W'((1 << code) - 1);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PRSC_W-1:0] code,
    input  logic              restart,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == div_limit(code));

    always_ff @(posedge clk) begin
        if (rst || restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_reload_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  timing_t          live,
    output logic [CNT_W-1:0] cnt,
    output logic             half_hit,
    output logic             full_hit
);
    logic at_top;

    assign at_top   = (cnt >= live.top);
    assign full_hit = tick && at_top;
    assign half_hit = tick && (cnt == live.mid);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_top ? live.init : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ldok_arm,
    input  logic              half_hit,
    input  logic              full_hit,
    output ctrl_t             ctrl,
    output timing_t           staged,
    output timing_t           live,
    output logic              ldok,
    output logic              load
);
    logic any_en;
    logic point_hit;

    assign any_en    = ctrl.half_en || ctrl.full_en;
    assign point_hit = (ctrl.half_en && half_hit) || (ctrl.full_en && full_hit);
    assign load      = ldok && any_en && (ctrl.immediate || point_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            staged <= '0;
            live   <= '0;
            ldok   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (reg_sel_e'(wr_addr))
                    SEL_CTRL: begin
                        ctrl.half_en   <= wr_data[BIT_HALF];
                        ctrl.full_en   <= wr_data[BIT_FULL];
                        ctrl.immediate <= wr_data[BIT_MODE];
                        if (!ldok) begin
                            staged.prsc <= wr_data[PRSC_W-1:0];
                        end
                    end
                    SEL_INIT: staged.init <= wr_data;
                    SEL_MID:  staged.mid  <= wr_data;
                    SEL_TOP:  staged.top  <= wr_data;
                    default:  ;
                endcase
            end
            if (load) begin
                live <= staged;
            end
            if (ldok_arm) begin
                ldok <= 1'b1;
            end else if (load) begin
                ldok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwm_dt_sampler.sv
module pwm_dt_sampler
    import pwm_reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_in,
    input  logic [NUM_DT-1:0] strobe,
    output logic [NUM_DT-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            for (int i = 0; i < NUM_DT; i++) begin
                if (strobe[i]) begin
                    stat[i] <= ext_in;
                end
            end
        end
    end
endmodule

// File: rtl/pwm_reload_core.sv
module pwm_reload_core
    import pwm_reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ldok_arm,
    input  logic              ext_in,
    input  logic [NUM_DT-1:0] dt_done,
    output logic [CNT_W-1:0]  cnt,
    output logic              ldok,
    output logic              reload,
    output logic [PRSC_W-1:0] prsc_staged,
    output logic [PRSC_W-1:0] prsc_live,
    output logic [NUM_DT-1:0] dt_stat
);
    ctrl_t   ctrl;
    timing_t staged;
    timing_t live;
    logic    tick;
    logic    half_hit;
    logic    full_hit;

    pwm_shadow_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ldok_arm (ldok_arm),
        .half_hit (half_hit),
        .full_hit (full_hit),
        .ctrl     (ctrl),
        .staged   (staged),
        .live     (live),
        .ldok     (ldok),
        .load     (reload)
    );

    pwm_prescaler u_div (
        .clk     (clk),
        .rst     (rst),
        .code    (live.prsc),
        .restart (reload),
        .tick    (tick)
    );

    pwm_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .live     (live),
        .cnt      (cnt),
        .half_hit (half_hit),
        .full_hit (full_hit)
    );

    pwm_dt_sampler u_dt (
        .clk    (clk),
        .rst    (rst),
        .ext_in (ext_in),
        .strobe (dt_done),
        .stat   (dt_stat)
    );

    assign prsc_staged = staged.prsc;
    assign prsc_live   = live.prsc;
endmodule

// File: rtl/pwm_reload_checks.sv
module pwm_reload_checks
    import pwm_reload_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              ldok_arm,
    input logic              ldok,
    input logic              reload,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  init_live,
    input logic [CNT_W-1:0]  top_live,
    input logic              half_en,
    input logic              full_en,
    input logic [PRSC_W-1:0] prsc_live,
    input logic [PRSC_W-1:0] prsc_staged,
    input logic [NUM_DT-1:0] dt_stat
);
    a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    a_r1_wrap_to_init: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt >= top_live) |=> cnt == $past(init_live));

    a_r4_prsc_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0 && ldok) |=> $stable(prsc_staged));

    a_r8_no_transfer_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (!half_en && !full_en) |=> $stable(prsc_live));

    a_r10_ldok_clears_on_transfer: assert property (@(posedge clk) disable iff (rst)
        (reload && !ldok_arm) |=> !ldok);

    a_r10_arm_sets_ldok: assert property (@(posedge clk) disable iff (rst)
        ldok_arm |=> ldok);

    a_r13_reset_clears_samples: assert property (@(posedge clk)
        rst |=> dt_stat == '0);
endmodule

bind pwm_reload_core pwm_reload_checks u_checks (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .ldok_arm    (ldok_arm),
    .ldok        (ldok),
    .reload      (reload),
    .tick        (tick),
    .cnt         (cnt),
    .init_live   (live.init),
    .top_live    (live.top),
    .half_en     (ctrl.half_en),
    .full_en     (ctrl.full_en),
    .prsc_live   (prsc_live),
    .prsc_staged (prsc_staged),
    .dt_stat     (dt_stat)
);

// File: tb/pwm_reload_core_test.sv
module pwm_reload_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ldok_arm = 1'b0;
    logic        ext_in = 1'b0;
    logic [1:0]  dt_done = '0;
    logic [15:0] cnt;
    logic        ldok;
    logic        reload;
    logic [2:0]  prsc_staged;
    logic [2:0]  prsc_live;
    logic [1:0]  dt_stat;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_reload_core uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ldok_arm(ldok_arm), .ext_in(ext_in), .dt_done(dt_done), .cnt(cnt),
        .ldok(ldok), .reload(reload), .prsc_staged(prsc_staged),
        .prsc_live(prsc_live), .dt_stat(dt_stat)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm();
        ldok_arm = 1'b1;
        @(negedge clk);
        ldok_arm = 1'b0;
    endtask

    task automatic wait_load(output int prev, output int cur, output int steps);
        prev = cnt; steps = 0;
        for (int i = 0; i < 600 && ldok; i++) begin
            prev = cnt;
            @(negedge clk);
            steps++;
        end
        cur = cnt;
    endtask

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 600 && cnt != 16'(v); i++) @(negedge clk);
    endtask

    task automatic cycles_to_change(output int k);
        int c0;
        c0 = cnt; k = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            k++;
            if (cnt != 16'(c0)) break;
        end
    endtask

    initial begin
        int prev, cur, steps, k, mx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset cnt", cnt, 0);
        check("R10 reset ldok", ldok, 0);
        check("R3 reset staged code", prsc_staged, 0);
        check("R13 reset samples", dt_stat, 0);

        // Immediate mode, end-of-period enable, start 0, limit 15.
        wr(1, 0); wr(3, 15); wr(0, 'h30);
        arm();
        wait_load(prev, cur, steps);
        check("R9 immediate transfer one clock after arming", steps, 1);

        // Sweep all divide codes.
        for (int p = 1; p < 8; p++) begin
            wr(0, 'h30 | p);
            check("R3 staged code read-back", prsc_staged, p);
            check("R3 live code unchanged before transfer", prsc_live, p - 1);
            arm();
            wait_load(prev, cur, steps);
            check("R3 live code after transfer", prsc_live, p);
            cycles_to_change(k);
            check("R11 first advance after transfer", k, 1 << p);
            cycles_to_change(k);
            check("R2 advance interval", k, 1 << p);
        end

        // Back to divide-by-1.
        wr(0, 'h30); arm(); wait_load(prev, cur, steps);
        check("R2 live code restored", prsc_live, 0);

        // Deferred end-of-period transfer, and code write while armed.
        wr(0, 'h10); wr(3, 3);
        wait_cnt(1);
        arm();
        wr(0, 'h15);
        check("R4 staged code kept while armed", prsc_staged, 0);
        check("R5 transfer pending before period end", ldok, 1);
        wait_load(prev, cur, steps);
        check("R5 transfer at period end (prev cnt)", prev, 15);
        check("R5 wrap after transfer", cur, 0);
        mx = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (cnt > mx) mx = cnt;
        end
        check("R5 new period limit live", mx, 3);

        // Deferred mid-cycle transfer (live compare value is 0).
        wr(0, 'h08); wr(2, 2); wr(3, 9);
        wait_cnt(1);
        arm();
        wait_load(prev, cur, steps);
        check("R6 transfer at mid compare (prev cnt)", prev, 0);
        check("R6 cnt after mid transfer", cur, 1);
        mx = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (cnt > mx) mx = cnt;
        end
        check("R6 new limit live", mx, 9);

        // Both reload points in one counter cycle.
        wr(0, 'h18);
        wait_cnt(5);
        arm();
        wait_load(prev, cur, steps);
        check("R7 first transfer at period end", prev, 9);
        check("R7 wrap value", cur, 0);
        arm();
        wait_load(prev, cur, steps);
        check("R7 second transfer at mid compare", prev, 2);
        check("R7 cnt after second transfer", cur, 3);

        // No enables: nothing moves, in immediate mode too.
        wr(0, 'h23);
        check("R3 staged code accepted while idle", prsc_staged, 3);
        arm();
        repeat (40) @(negedge clk);
        check("R8 ldok stays set", ldok, 1);
        check("R8 live code unchanged", prsc_live, 0);
        wr(0, 'h30);
        @(negedge clk);
        check("R8 transfer once enabled", ldok, 0);
        check("R4 armed write left staged code", prsc_live, 3);
        wr(0, 'h30); arm(); wait_load(prev, cur, steps);

        // Start value honoured at wrap.
        wr(1, 5); wr(3, 8); arm(); wait_load(prev, cur, steps);
        wait_cnt(8);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R1 sequence from start value", cnt, (i == 4) ? 5 : 5 + i);
        end

        // Transfer and staged write in the same cycle.
        ldok_arm = 1'b1;
        @(negedge clk);
        ldok_arm = 1'b0;
        wr(3, 12);
        check("R12 transfer done", ldok, 0);
        wait_cnt(8);
        @(negedge clk);
        check("R12 old limit went live", cnt, 5);
        arm(); wait_load(prev, cur, steps);
        wait_cnt(12);
        check("R12 new limit reached", cnt, 12);
        @(negedge clk);
        check("R12 wrap at new limit", cnt, 5);

        // Arming pulse coincident with a transfer keeps ldok set.
        ldok_arm = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 arm during transfer keeps ldok", ldok, 1);
        ldok_arm = 1'b0;
        @(negedge clk);
        check("R10 ldok cleared by next transfer", ldok, 0);

        // Deadtime sampling.
        ext_in = 1'b1; dt_done = 2'b01; @(negedge clk); dt_done = 2'b00;
        check("R13 sample 0 high", dt_stat, 1);
        ext_in = 1'b0; dt_done = 2'b10; @(negedge clk); dt_done = 2'b00;
        check("R13 sample 1 low", dt_stat, 1);
        ext_in = 1'b1; dt_done = 2'b10; @(negedge clk); dt_done = 2'b00;
        check("R13 sample 1 high", dt_stat, 3);
        ext_in = 1'b0; dt_done = 2'b01; @(negedge clk); dt_done = 2'b00;
        check("R13 sample 0 low", dt_stat, 2);
        ext_in = 1'b1; @(negedge clk);
        check("R13 no strobe holds", dt_stat, 2);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R13 reset clears samples", dt_stat, 0);
        check("R1 reset clears cnt", cnt, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule